// File: doc/BRIEF.md
# Serial Flash Programming Target Controller

This block is the device end of a two-wire serial programming link for a small flash memory with 14-bit words. An external programmer toggles a programming clock and a data line. The block samples both pins with the core clock and takes bits on each falling edge of the programming clock. It decodes 6-bit commands and their 16-bit payloads. It keeps an address counter that spans a user space and a separate configuration space, and it sends read data back on the same data line.

Write data first goes into a row of 32 latches. A begin-programming command moves the valid latches into a behavioural flash array, and that write can only clear bits. Programming can be timed internally or externally. Bulk erase and programming durations are cycle counts set by parameters. While a duration runs, `busy_o` stays high and the block ignores all traffic on the pins. Programming mode is one level input.

Top module: `ser_prog_target`

## Requirements
- R1: After reset `pdat_oe_o` and `busy_o` are low, the address is 0, and every user word reads 3FFFh.
- R2: Load-data (code 02h) puts the payload into a latch. Begin-internal (code 08h) writes every valid latch into the array, then holds `busy_o` high for PROG_CYC core cycles.
- R3: Programming never erases first. The stored word becomes the bitwise AND of its old value and the latch value.
- R4: Increment (06h) changes only the low SPACE_AW address bits. The top user address (1FFFh by default) wraps to 0, and the top configuration address (3FFFh) wraps to the configuration base (2000h).
- R5: Load-config (00h) moves the address to the configuration base and then takes a payload like load-data. Only reset-address (16h) or leaving programming mode returns the address to user space. Base+6 reads the DEV_ID parameter.
- R6: A programming write aimed at base+6 is ignored.
- R7: The low 5 address bits select the latch slot, so a 33rd load overwrites an earlier slot. A begin command programs the 32-word row that holds the current address.
- R8: Begin-external (18h) programs without raising `busy_o`. End-external (0Ah) raises `busy_o` for DIS_CYC cycles.
- R9: Bulk erase (09h) sets every user word and every configuration word to 3FFFh, except the calibration words at base+9 and base+10. It then holds `busy_o` for ERASE_CYC cycles.
- R10: When bit CP_BIT (7) of the word at base+7 is 0, user-space reads return 0000h and configuration reads are unaffected. Bulk erase clears this protection.
- R11: Frame format:
  - A command is 6 bits, least significant bit first, taken on falling edges of `pclk_i`.
  - A payload is 16 bits, least significant bit first: a 0 start bit, 14 data bits, then a 0 stop bit.
  - For read (04h), `pdat_oe_o` goes high after the command's last falling edge and stays high until the 16th payload falling edge.
  - During a read, `pdat_o` presents frame bit k from falling edge k onward.
- R12: While `prog_en_i` is low the address is held at 0, the bit parser returns to idle, the latches are cleared and `pdat_oe_o` is low. Array contents are kept.
- R13: Falling edges of `pclk_i` that arrive while `busy_o` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_en_i | input | 1 | Programming mode enable |
| pclk_i | input | 1 | Programming clock from the host |
| pdat_i | input | 1 | Programming data from the host |
| pdat_o | output | 1 | Read data toward the host |
| pdat_oe_o | output | 1 | Output enable for the data pin |
| busy_o | output | 1 | Erase, program or discharge interval running |

## Verification
If the address counter is wrong, the very next read frame returns data from a different word. So every increment, wrap and space change can be seen within one command. If the latch valid bits or the row selection are wrong, the error shows only at the next begin command, as unexpected words in readback. A stuck busy counter shows right away at `busy_o`, and also as commands that are swallowed or acted on too early. A parser that is off by one bit turns every later command into garbage, so the first read after the fault exposes it.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int CMD_W   = 6;
  localparam int WORD_W  = 14;
  localparam int FRAME_W = 16;
  localparam int LATCHES = 32;
  localparam int ID_IDX  = 6;
  localparam int CW1_IDX = 7;
  localparam int CAL0_IDX = 9;
  localparam int CAL1_IDX = 10;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOAD_CFG = 6'h00,
    CMD_LOAD_DAT = 6'h02,
    CMD_READ     = 6'h04,
    CMD_INC      = 6'h06,
    CMD_PROG_INT = 6'h08,
    CMD_ERASE    = 6'h09,
    CMD_END_EXT  = 6'h0A,
    CMD_RST_ADDR = 6'h16,
    CMD_PROG_EXT = 6'h18
  } cmd_e;

  typedef enum logic [1:0] {ST_CMD, ST_LOAD, ST_READ} rx_st_e;
endpackage

// File: rtl/spt_pin_sync.sv
module spt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_i,
  input  logic pdat_i,
  output logic fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_sr, dat_sr;
  logic clk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sr <= '0;
      dat_sr <= '0;
      clk_d  <= 1'b0;
    end else begin
      clk_sr <= {clk_sr[STAGES-2:0], pclk_i};
      dat_sr <= {dat_sr[STAGES-2:0], pdat_i};
      clk_d  <= clk_sr[STAGES-1];
    end
  end

  assign fall_o = clk_d & ~clk_sr[STAGES-1];
  assign dat_o  = dat_sr[STAGES-1];
endmodule

// File: rtl/spt_addr_ctr.sv
module spt_addr_ctr #(
  parameter int SPACE_AW = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rst_addr_i,
  input  logic              to_cfg_i,
  input  logic              inc_i,
  output logic [SPACE_AW:0] addr_o
);
  localparam logic [SPACE_AW:0] CFG_BASE = {1'b1, {SPACE_AW{1'b0}}};

  logic [SPACE_AW:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    addr_q <= '0;
    else if (clear_i || rst_addr_i) addr_q <= '0;
    else if (to_cfg_i)              addr_q <= CFG_BASE;
    else if (inc_i)                 addr_q <= {addr_q[SPACE_AW], addr_q[SPACE_AW-1:0] + 1'b1};
  end

  assign addr_o = addr_q;

  // R4
  space_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clear_i && !rst_addr_i && !to_cfg_i && (&addr_q[SPACE_AW-1:0]))
    |=> (addr_q[SPACE_AW-1:0] == '0 && addr_q[SPACE_AW] == $past(addr_q[SPACE_AW])));
endmodule

// File: rtl/spt_flash.sv
module spt_flash
  import spt_pkg::*;
#(
  parameter int SPACE_AW  = 13,
  parameter int UMEM_AW   = 7,
  parameter int CFG_AW    = 4,
  parameter int PROG_CYC  = 1000,
  parameter int ERASE_CYC = 4000,
  parameter int DIS_CYC   = 200,
  parameter logic [WORD_W-1:0] DEV_ID    = 14'h0C2,
  parameter logic [WORD_W-1:0] CAL0_INIT = 14'h1234,
  parameter logic [WORD_W-1:0] CAL1_INIT = 14'h2BCD,
  parameter int CP_BIT    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic              prog_int_i,
  input  logic              prog_ext_i,
  input  logic              end_ext_i,
  input  logic              erase_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [SPACE_AW:0] addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              busy_o
);
  localparam int ROW_AW = $clog2(LATCHES);
  localparam int UWORDS = 1 << UMEM_AW;
  localparam int CWORDS = 1 << CFG_AW;
  localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? ((PROG_CYC > DIS_CYC) ? PROG_CYC : DIS_CYC)
                                                 : ((ERASE_CYC > DIS_CYC) ? ERASE_CYC : DIS_CYC);
  localparam int CNT_W  = $clog2(MAXC + 1);

  logic [WORD_W-1:0]  umem  [UWORDS];
  logic [WORD_W-1:0]  cmem  [CWORDS];
  logic [WORD_W-1:0]  lat_q [LATCHES];
  logic [LATCHES-1:0] lat_v;
  logic [CNT_W-1:0]   cnt_q;
  logic [UMEM_AW-1:0] u_idx [LATCHES];
  logic [LATCHES-1:0] c_ok;
  logic               cp_on;

  for (genvar g = 0; g < LATCHES; g++) begin : g_slot
    assign u_idx[g] = {addr_i[UMEM_AW-1:ROW_AW], ROW_AW'(g)};
    if (g < CWORDS && g != ID_IDX) begin : g_wr
      assign c_ok[g] = (addr_i[SPACE_AW-1:ROW_AW] == '0);
    end else begin : g_ro
      assign c_ok[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < UWORDS; i++) umem[i] <= '1;
      for (int i = 0; i < CWORDS; i++)
        cmem[i] <= (i == CAL0_IDX) ? CAL0_INIT : (i == CAL1_IDX) ? CAL1_INIT : '1;
      for (int i = 0; i < LATCHES; i++) lat_q[i] <= '1;
      lat_v <= '0;
      cnt_q <= '0;
    end else begin
      if (clear_i) lat_v <= '0;
      else if (load_i) begin
        lat_q[addr_i[ROW_AW-1:0]] <= data_i;
        lat_v[addr_i[ROW_AW-1:0]] <= 1'b1;
      end
      if (prog_int_i || prog_ext_i) begin
        lat_v <= '0;
        for (int i = 0; i < LATCHES; i++) begin
          if (lat_v[i]) begin
            if (!addr_i[SPACE_AW]) umem[u_idx[i]] <= umem[u_idx[i]] & lat_q[i];
            else if (c_ok[i])      cmem[CFG_AW'(i)] <= cmem[CFG_AW'(i)] & lat_q[i];
          end
        end
      end
      if (erase_i) begin
        for (int i = 0; i < UWORDS; i++) umem[i] <= '1;
        for (int i = 0; i < CWORDS; i++)
          if (i != CAL0_IDX && i != CAL1_IDX) cmem[i] <= '1;
      end
      if (prog_int_i)      cnt_q <= CNT_W'(PROG_CYC);
      else if (erase_i)    cnt_q <= CNT_W'(ERASE_CYC);
      else if (end_ext_i)  cnt_q <= CNT_W'(DIS_CYC);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cp_on  = ~cmem[CW1_IDX][CP_BIT];
  assign busy_o = (cnt_q != '0);

  always_comb begin
    if (!addr_i[SPACE_AW])                       rd_data_o = cp_on ? '0 : umem[addr_i[UMEM_AW-1:0]];
    else if (addr_i[SPACE_AW-1:CFG_AW] != '0)    rd_data_o = '1;
    else if (addr_i[CFG_AW-1:0] == CFG_AW'(ID_IDX)) rd_data_o = DEV_ID;
    else                                         rd_data_o = cmem[addr_i[CFG_AW-1:0]];
  end

  // R13
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(load_i || prog_int_i || prog_ext_i || end_ext_i || erase_i));

  // R9
  cal_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (cmem[CAL0_IDX] == $past(cmem[CAL0_IDX]) &&
                 cmem[CAL1_IDX] == $past(cmem[CAL1_IDX]) && !cp_on));
endmodule

// File: rtl/ser_prog_target.sv
module ser_prog_target
  import spt_pkg::*;
#(
  parameter int SPACE_AW    = 13,
  parameter int UMEM_AW     = 7,
  parameter int CFG_AW      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYC    = 1000,
  parameter int ERASE_CYC   = 4000,
  parameter int DIS_CYC     = 200,
  parameter logic [13:0] DEV_ID    = 14'h0C2,
  parameter logic [13:0] CAL0_INIT = 14'h1234,
  parameter logic [13:0] CAL1_INIT = 14'h2BCD,
  parameter int CP_BIT      = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_en_i,
  input  logic pclk_i,
  input  logic pdat_i,
  output logic pdat_o,
  output logic pdat_oe_o,
  output logic busy_o
);
  localparam int BIT_W = $clog2(FRAME_W);

  logic fall, dat, busy;
  logic [SPACE_AW:0]  addr;
  logic [WORD_W-1:0]  rd_data;
  rx_st_e             st_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-2:0] sh_q;
  logic [FRAME_W-1:0] frame_q;
  logic               oe_q;
  logic [CMD_W-1:0]   cmd;
  logic op_load, op_cfg, op_inc, op_rsta, op_pint, op_pext, op_eext, op_erase;
  logic [WORD_W-1:0]  op_data;

  spt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pclk_i, .pdat_i, .fall_o(fall), .dat_o(dat)
  );

  spt_addr_ctr #(.SPACE_AW(SPACE_AW)) u_addr (
    .clk_i, .rst_ni, .clear_i(!prog_en_i), .rst_addr_i(op_rsta),
    .to_cfg_i(op_cfg), .inc_i(op_inc), .addr_o(addr)
  );

  spt_flash #(
    .SPACE_AW(SPACE_AW), .UMEM_AW(UMEM_AW), .CFG_AW(CFG_AW),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .DIS_CYC(DIS_CYC),
    .DEV_ID(DEV_ID), .CAL0_INIT(CAL0_INIT), .CAL1_INIT(CAL1_INIT), .CP_BIT(CP_BIT)
  ) u_flash (
    .clk_i, .rst_ni, .clear_i(!prog_en_i), .load_i(op_load), .prog_int_i(op_pint),
    .prog_ext_i(op_pext), .end_ext_i(op_eext), .erase_i(op_erase), .data_i(op_data),
    .addr_i(addr), .rd_data_o(rd_data), .busy_o(busy)
  );

  assign cmd = {dat, sh_q[FRAME_W-2 -: CMD_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_CMD; bit_q <= '0; sh_q <= '0; frame_q <= '0; oe_q <= 1'b0;
      {op_load, op_cfg, op_inc, op_rsta, op_pint, op_pext, op_eext, op_erase} <= '0;
      op_data <= '0;
    end else begin
      {op_load, op_cfg, op_inc, op_rsta, op_pint, op_pext, op_eext, op_erase} <= '0;
      if (!prog_en_i) begin
        st_q <= ST_CMD; bit_q <= '0; oe_q <= 1'b0;
      end else if (fall) begin
        if (busy) begin
          st_q <= ST_CMD; bit_q <= '0;
        end else begin
          sh_q  <= {dat, sh_q[FRAME_W-2:1]};
          bit_q <= bit_q + 1'b1;
          unique case (st_q)
            ST_CMD: if (bit_q == BIT_W'(CMD_W-1)) begin
              bit_q <= '0;
              case (cmd)
                CMD_LOAD_CFG: begin op_cfg <= 1'b1; st_q <= ST_LOAD; end
                CMD_LOAD_DAT: st_q <= ST_LOAD;
                CMD_READ: begin
                  st_q <= ST_READ; oe_q <= 1'b1;
                  frame_q <= {1'b0, rd_data, 1'b0};
                end
                CMD_INC:      op_inc   <= 1'b1;
                CMD_RST_ADDR: op_rsta  <= 1'b1;
                CMD_PROG_INT: op_pint  <= 1'b1;
                CMD_PROG_EXT: op_pext  <= 1'b1;
                CMD_END_EXT:  op_eext  <= 1'b1;
                CMD_ERASE:    op_erase <= 1'b1;
                default: ;
              endcase
            end
            ST_LOAD: if (bit_q == BIT_W'(FRAME_W-1)) begin
              op_load <= 1'b1;
              op_data <= sh_q[WORD_W:1];
              st_q <= ST_CMD; bit_q <= '0;
            end
            ST_READ: if (bit_q == BIT_W'(FRAME_W-1)) begin
              st_q <= ST_CMD; bit_q <= '0; oe_q <= 1'b0;
            end
            default: st_q <= ST_CMD;
          endcase
        end
      end
    end
  end

  assign pdat_oe_o = oe_q;
  assign pdat_o    = oe_q & frame_q[bit_q];
  assign busy_o    = busy;

  // R12
  exit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en_i |=> !pdat_oe_o);

  // R11
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdat_oe_o) |-> !pdat_o);
endmodule

// File: tb/ser_prog_target_tb.sv
module ser_prog_target_tb;
  localparam int SAW = 7;
  localparam int CB  = 1 << SAW;
  localparam int HP  = 4;
  localparam int PROG = 100, ERASE = 300, DIS = 80;
  localparam logic [13:0] DEVID = 14'h1A5, CAL0 = 14'h1234, CAL1 = 14'h2BCD;
  localparam logic [5:0] C_LCFG = 6'h00, C_LDAT = 6'h02, C_RD = 6'h04, C_INC = 6'h06,
                         C_PINT = 6'h08, C_ERA = 6'h09, C_EEXT = 6'h0A, C_RSTA = 6'h16,
                         C_PEXT = 6'h18;

  logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b1, pclk = 1'b0, pdat = 1'b0;
  logic pdat_o, pdat_oe, busy;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ser_prog_target #(
    .SPACE_AW(SAW), .UMEM_AW(7), .PROG_CYC(PROG), .ERASE_CYC(ERASE), .DIS_CYC(DIS),
    .DEV_ID(DEVID), .CAL0_INIT(CAL0), .CAL1_INIT(CAL1)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_en_i(prog_en), .pclk_i(pclk), .pdat_i(pdat),
    .pdat_o(pdat_o), .pdat_oe_o(pdat_oe), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      pdat = v[k]; pclk = 1'b1;
      repeat (HP) @(negedge clk);
      pclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [5:0] c);
    send_bits(16'(c), 6);
  endtask

  task automatic load(input logic [5:0] c, input logic [13:0] d);
    cmd(c);
    send_bits({1'b0, d, 1'b0}, 16);
  endtask

  task automatic incn(input int n);
    for (int k = 0; k < n; k++) cmd(C_INC);
  endtask

  task automatic rd(output logic [13:0] d, output logic [15:0] fr, output logic [15:0] oe);
    cmd(C_RD);
    for (int k = 0; k < 16; k++) begin
      pdat = 1'b0; pclk = 1'b1;
      repeat (HP) @(negedge clk);
      fr[k] = pdat_o; oe[k] = pdat_oe;
      pclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
    d = fr[14:1];
  endtask

  function automatic logic [13:0] rdv_dummy(input logic [13:0] x);
    return x;
  endfunction

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 10000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic prog_wait;
    int c;
    cmd(C_PINT);
    repeat (4) @(negedge clk);
    wait_idle(c);
  endtask

  task automatic read_chk(input string req, input int exp);
    logic [13:0] d; logic [15:0] fr, oe;
    rd(d, fr, oe);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 oe after reset", pdat_oe, 0);
    chk("R1 busy after reset", busy, 0);
    read_chk("R1 erased word at 0", 14'h3FFF);
  endtask

  task automatic t_frame;
    logic [13:0] d; logic [15:0] fr, oe;
    chk("R11 oe idle before read", pdat_oe, 0);
    rd(d, fr, oe);
    chk("R11 oe over 16 frame bits", oe, 16'hFFFF);
    chk("R11 start bit", fr[0], 0);
    chk("R11 stop bit", fr[15], 0);
    chk("R11 oe released after stop", pdat_oe, 0);
  endtask

  task automatic t_prog_int;
    int c;
    load(C_LDAT, 14'h1555);
    cmd(C_PINT);
    repeat (4) @(negedge clk);
    chk("R2 busy during internal program", busy, 1);
    wait_idle(c);
    chk("R2 busy length in window", int'(c >= PROG - 12 && c <= PROG), 1);
    read_chk("R2 programmed word", 14'h1555);
  endtask

  task automatic t_no_erase;
    load(C_LDAT, 14'h0F0F);
    prog_wait();
    read_chk("R3 AND with old contents", 14'h1555 & 14'h0F0F);
  endtask

  task automatic t_user_wrap;
    cmd(C_RSTA);
    incn(CB - 1);
    load(C_LDAT, 14'h2222);
    prog_wait();
    read_chk("R4 word at top of user space", 14'h2222);
    cmd(C_INC);
    read_chk("R4 user wrap to 0", 14'h0505);
  endtask

  task automatic t_cfg;
    load(C_LCFG, 14'h3FFF);
    incn(6);
    read_chk("R5 device id in config space", DEVID);
    load(C_LDAT, 14'h0000);
    prog_wait();
    read_chk("R6 device id write ignored", DEVID);
    incn(CB - 1 - 6);
    read_chk("R4 top of config space reserved", 14'h3FFF);
    cmd(C_INC);
    incn(6);
    read_chk("R4 config wrap stays in config space", DEVID);
    cmd(C_RSTA);
    read_chk("R5 reset address returns to user 0", 14'h0505);
  endtask

  task automatic t_latch_over;
    cmd(C_RSTA);
    for (int k = 0; k <= 32; k++) begin
      load(C_LDAT, 14'h1000 + 14'(k));
      if (k < 32) cmd(C_INC);
    end
    prog_wait();
    cmd(C_RSTA);
    read_chk("R7 row 0 untouched", 14'h0505);
    incn(32);
    read_chk("R7 slot 0 overwritten by 33rd load", 14'h1020);
    cmd(C_INC);
    read_chk("R7 slot 1 keeps its load", 14'h1001);
  endtask

  task automatic t_ext;
    int c;
    load(C_LDAT, 14'h0FF1);
    cmd(C_PEXT);
    repeat (4) @(negedge clk);
    chk("R8 no busy after external begin", busy, 0);
    cmd(C_EEXT);
    repeat (4) @(negedge clk);
    chk("R8 busy after external end", busy, 1);
    cmd(C_INC);
    chk("R13 still busy while increment sent", busy, 1);
    wait_idle(c);
    chk("R8 discharge interval shorter than program", int'(c < DIS), 1);
    read_chk("R8 R13 external program at unchanged address", 14'h1001 & 14'h0FF1);
  endtask

  task automatic t_cp;
    load(C_LCFG, 14'h3FFF);
    incn(7);
    load(C_LDAT, 14'h3F7F);
    prog_wait();
    read_chk("R10 config word with CP bit cleared", 14'h3F7F);
    cmd(C_RSTA);
    read_chk("R10 protected user read", 14'h0000);
  endtask

  task automatic t_erase;
    int c;
    cmd(C_ERA);
    repeat (4) @(negedge clk);
    chk("R9 busy during erase", busy, 1);
    wait_idle(c);
    chk("R9 erase length in window", int'(c >= ERASE - 12 && c <= ERASE), 1);
    cmd(C_RSTA);
    read_chk("R9 R10 user word erased and readable", 14'h3FFF);
    load(C_LCFG, 14'h3FFF);
    incn(7);
    read_chk("R9 config word erased", 14'h3FFF);
    incn(2);
    read_chk("R9 calibration word 0 kept", CAL0);
    cmd(C_INC);
    read_chk("R9 calibration word 1 kept", CAL1);
  endtask

  task automatic t_exit;
    cmd(C_RSTA);
    load(C_LDAT, 14'h0AAA);
    prog_wait();
    load(C_LCFG, 14'h3FFF);
    prog_en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12 oe low outside mode", pdat_oe, 0);
    prog_en = 1'b1;
    send_bits(16'h0005, 3);
    prog_en = 1'b0;
    repeat (6) @(negedge clk);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R12 address and parser reset on exit", 14'h0AAA);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_frame();
    t_prog_int();
    t_no_erase();
    t_user_wrap();
    t_cfg();
    t_latch_over();
    t_ext();
    t_cp();
    t_erase();
    t_exit();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule